// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is the integer arithmetic and logic unit of a small 32-bit RISC pipeline. Each cycle it takes two 32-bit operands and a 6-bit function code. It produces a 32-bit result and a flag that is set when that result is zero. The supported operations are add, subtract, increment, decrement, bitwise AND, OR and complement, left shifts, arithmetic and logical right shifts, and signed set-less-than.

Register-register instructions feed the second register value as operand B. Immediate instructions feed the 16-bit immediate, already extended by the decoder, on the same input and select the same function codes. The unit itself never sees the opcode field. The result and the flag are captured in an output register, so the values computed from one cycle's inputs appear one clock later. An active-low asynchronous reset clears that register.

Top module: `func_alu`

## Requirements
- R1: Function code 000000 gives A+B and code 000001 gives A−B, both modulo 2^32.
- R2: Code 000100 gives A+1 and code 000101 gives A−1, both modulo 2^32; operand B has no effect on either.
- R3: Code 000010 gives A AND B, code 000011 gives A OR B, and code 000110 gives the bitwise inverse of A with operand B having no effect.
- R4: Codes 001100 (logical) and 001000 (arithmetic) both shift A left by the shift distance and fill the vacated bits with zeros.
- R5: Code 001010 shifts A right by the shift distance and copies A bit 31 into the vacated bits; code 001110 shifts right and fills them with zeros.
- R6: The shift distance is B bits 4:0 only; B bits 31:5 have no effect on any shift.
- R7: Code 001001 compares A and B as signed two's-complement numbers and gives 1 when A < B, otherwise 0.
- R8: Any function code not listed in R1 to R7 gives a result of zero.
- R9: The zero flag is 1 exactly when the 32-bit result output is all zeros.
- R10: The result and flag for inputs present at a rising clock edge appear after that edge and hold until the next one; while reset is low the result is 0 and the flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B (register value or extended immediate) |
| func_i | input | 6 | Function code |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, set when result_o is zero |

## Verification
Every result and flag is due one clock after its inputs are captured. The outputs change only at the rising edge where operands and code are sampled. The bench therefore changes inputs on a falling edge and compares the outputs on the next falling edge, half a period after the capturing edge. In the latency test it also samples shortly before the capturing edge, to confirm the previous value is still held until that edge.

// File: rtl/func_alu_pkg.sv
package func_alu_pkg;

    localparam int DATA_W = 32;
    localparam int FUNC_W = 6;
    localparam int SHW    = $clog2(DATA_W);

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD  = 6'b000000,
        FN_SUB  = 6'b000001,
        FN_AND  = 6'b000010,
        FN_OR   = 6'b000011,
        FN_INC  = 6'b000100,
        FN_DEC  = 6'b000101,
        FN_COMP = 6'b000110,
        FN_SLA  = 6'b001000,
        FN_SLT  = 6'b001001,
        FN_SRA  = 6'b001010,
        FN_SLL  = 6'b001100,
        FN_SRL  = 6'b001110
    } func_e;

    typedef enum logic [1:0] {
        AR_ADD,
        AR_SUB,
        AR_INC,
        AR_DEC
    } arith_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_NOT
    } logic_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
    } alu_state_t;

endpackage

// File: rtl/func_alu_arith.sv
module func_alu_arith
    import func_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  arith_e       mode_i,
    output logic [W-1:0] sum_o,
    output logic         lt_o
);

    logic [W-1:0] b_eff;
    logic         carry_in;

    // One adder serves add, subtract, increment, decrement and compare.
    always_comb begin
        b_eff    = b_i;
        carry_in = 1'b0;
        unique case (mode_i)
            AR_ADD: begin b_eff = b_i;  carry_in = 1'b0; end
            AR_SUB: begin b_eff = ~b_i; carry_in = 1'b1; end
            AR_INC: begin b_eff = '0;   carry_in = 1'b1; end
            AR_DEC: begin b_eff = '1;   carry_in = 1'b0; end
            default: begin b_eff = b_i; carry_in = 1'b0; end
        endcase
    end

    assign sum_o = a_i + b_eff + W'(carry_in);

    // Signed less-than; meaningful when mode_i selects subtraction.
    assign lt_o = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : sum_o[W-1];

endmodule

// File: rtl/func_alu_logic.sv
module func_alu_logic
    import func_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_e       mode_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        unique case (mode_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_NOT:  y_o = ~a_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/func_alu_shift.sv
module func_alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           arith_i,
    output logic [W-1:0]   shl_o,
    output logic [W-1:0]   shr_o
);

    logic         fill;
    logic [W-1:0] lstg [SHW+1];
    logic [W-1:0] rstg [SHW+1];

    assign fill    = arith_i & a_i[W-1];
    assign lstg[0] = a_i;
    assign rstg[0] = a_i;

    // Logarithmic barrel: stage k moves by 2**k when amount bit k is set.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign lstg[k+1] = amt_i[k] ? {lstg[k][W-1-S:0], {S{1'b0}}} : lstg[k];
        assign rstg[k+1] = amt_i[k] ? {{S{fill}}, rstg[k][W-1:S]}   : rstg[k];
    end

    assign shl_o = lstg[SHW];
    assign shr_o = rstg[SHW];

endmodule

// File: rtl/func_alu.sv
module func_alu
    import func_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o
);

    arith_e            arith_mode;
    logic_e            logic_mode;
    logic              shift_arith;
    logic [DATA_W-1:0] sum;
    logic              lt;
    logic [DATA_W-1:0] lg_y;
    logic [DATA_W-1:0] shl;
    logic [DATA_W-1:0] shr;

    alu_state_t state_d;
    alu_state_t state_q;

    always_comb begin
        unique case (func_i)
            FN_SUB, FN_SLT: arith_mode = AR_SUB;
            FN_INC:         arith_mode = AR_INC;
            FN_DEC:         arith_mode = AR_DEC;
            default:        arith_mode = AR_ADD;
        endcase
        unique case (func_i)
            FN_OR:   logic_mode = LG_OR;
            FN_COMP: logic_mode = LG_NOT;
            default: logic_mode = LG_AND;
        endcase
        shift_arith = (func_i == FN_SRA);
    end

    func_alu_arith #(.W(DATA_W)) u_arith (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .mode_i (arith_mode),
        .sum_o  (sum),
        .lt_o   (lt)
    );

    func_alu_logic #(.W(DATA_W)) u_logic (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .mode_i (logic_mode),
        .y_o    (lg_y)
    );

    func_alu_shift #(.W(DATA_W), .SHW(SHW)) u_shift (
        .a_i     (opa_i),
        .amt_i   (opb_i[SHW-1:0]),
        .arith_i (shift_arith),
        .shl_o   (shl),
        .shr_o   (shr)
    );

    always_comb begin
        state_d = state_q;
        unique case (func_i)
            FN_ADD, FN_SUB, FN_INC, FN_DEC: state_d.result = sum;
            FN_AND, FN_OR, FN_COMP:         state_d.result = lg_y;
            FN_SLA, FN_SLL:                 state_d.result = shl;
            FN_SRA, FN_SRL:                 state_d.result = shr;
            FN_SLT:                         state_d.result = DATA_W'(lt);
            default:                        state_d.result = '0;
        endcase
        state_d.zero = (state_d.result == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{result: '0, zero: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign zero_o   = state_q.zero;

endmodule

// File: rtl/func_alu_chk.sv
module func_alu_chk
    import func_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [FUNC_W-1:0] func_i,
    input logic [DATA_W-1:0] result_o,
    input logic              zero_o
);

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == FN_ADD) |=> (result_o == $past(opa_i) + $past(opb_i)));

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == FN_INC) |=> (result_o == $past(opa_i) + 32'd1));

    // R3
    comp_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == FN_COMP) |=> (result_o == ~$past(opa_i)));

    // R7
    slt_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == FN_SLT) |=> (result_o[DATA_W-1:1] == '0));

    // R8
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(func_i inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_INC, FN_DEC, FN_COMP,
                         FN_SLA, FN_SLT, FN_SRA, FN_SLL, FN_SRL})
        |=> (result_o == '0));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (result_o == '0));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && zero_o));

endmodule

bind func_alu func_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .func_i   (func_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/func_alu_tb_top.sv
module func_alu_tb_top;

    localparam int PERIOD = 20;

    typedef struct packed {
        logic [5:0]  f;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{6'b000000, 32'h00000005, 32'h00000007, 32'h0000000C, 4'd1},  // R1 add
        '{6'b000000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'd1},  // R1 wrap
        '{6'b000001, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 4'd1},  // R1 sub
        '{6'b000001, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'd1},  // R1 sub wrap
        '{6'b000100, 32'h7FFFFFFF, 32'h12345678, 32'h80000000, 4'd2},  // R2 inc
        '{6'b000101, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd2},  // R2 dec
        '{6'b000010, 32'hF0F0FF00, 32'h0FF0F0F0, 32'h00F0F000, 4'd3},  // R3 and
        '{6'b000011, 32'hF0F0FF00, 32'h0FF0F0F0, 32'hFFF0FFF0, 4'd3},  // R3 or
        '{6'b000110, 32'h0000FFFF, 32'hAAAAAAAA, 32'hFFFF0000, 4'd3},  // R3 comp
        '{6'b001100, 32'h00000001, 32'h0000001F, 32'h80000000, 4'd4},  // R4 sll
        '{6'b001000, 32'h80000003, 32'h00000001, 32'h00000006, 4'd4},  // R4 sla
        '{6'b001010, 32'h80000000, 32'h00000004, 32'hF8000000, 4'd5},  // R5 sra
        '{6'b001110, 32'h80000000, 32'h00000004, 32'h08000000, 4'd5},  // R5 srl
        '{6'b001010, 32'h40000000, 32'h0000001E, 32'h00000001, 4'd5},  // R5 sra pos
        '{6'b001100, 32'h00000001, 32'h00000021, 32'h00000002, 4'd6},  // R6 sll
        '{6'b001110, 32'hF0000000, 32'hFFFFFFE4, 32'h0F000000, 4'd6},  // R6 srl
        '{6'b001001, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 4'd7},  // R7 -1<1
        '{6'b001001, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 4'd7},  // R7 1<-1
        '{6'b001001, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 4'd7},  // R7 min<max
        '{6'b001001, 32'h00000005, 32'h00000005, 32'h00000000, 4'd7},  // R7 equal
        '{6'b111111, 32'h12345678, 32'h00000001, 32'h00000000, 4'd8},  // R8
        '{6'b000111, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [5:0]  func = '0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int failures = 0;

    always #(PERIOD/2) clk = ~clk;

    func_alu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .opa_i    (opa),
        .opb_i    (opb),
        .func_i   (func),
        .result_o (result),
        .zero_o   (zero)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, compare on the next falling edge.
    task automatic run(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] e, input string req);
        @(negedge clk);
        func = f; opa = a; opb = b;
        @(negedge clk);
        check(req, result, e);
        check("R9", {31'd0, zero}, {31'd0, e == 32'd0});
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        check("R10 reset result", result, 32'd0);
        check("R10 reset flag", {31'd0, zero}, 32'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].f, VECS[i].a, VECS[i].b, VECS[i].e,
                $sformatf("R%0d vec%0d", VECS[i].r, i));
        end

        // R2 B ignored: same A, different B, same result
        run(6'b000100, 32'h00000010, 32'h00000000, 32'h00000011, "R2 inc b=0");
        run(6'b000101, 32'h00000010, 32'hDEADBEEF, 32'h0000000F, "R2 dec b junk");
        // R3 comp ignores B
        run(6'b000110, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, "R3 comp b=0");
        // R4 / R5 zero shift
        run(6'b001010, 32'h80000001, 32'h00000020, 32'h80000001, "R6 sra amt 32 -> 0");

        // R10 latency: output holds until the capturing edge
        run(6'b000000, 32'h00000001, 32'h00000001, 32'h00000002, "R10 prime");
        @(negedge clk);
        func = 6'b000000; opa = 32'h00000100; opb = 32'h00000001;
        #(PERIOD/2 - 2);
        check("R10 held before edge", result, 32'h00000002);
        @(negedge clk);
        check("R10 after edge", result, 32'h00000101);

        // R10 reset mid-run clears result
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R10 async clear", result, 32'd0);
        check("R10 async flag", {31'd0, zero}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        run(6'b001001, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000001, "R7 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule